// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a linear address into a physical address by reading a two-level translation structure from memory. One request carries the linear address, an access kind (read, write or instruction fetch) and a flag that says whether the access comes from user or kernel privilege. The frame number of the top-level directory comes in on its own input. The walker reads the directory entry and then the table entry through a single-outstanding memory port. It checks presence, write permission and the user restriction at both levels. It then returns either the physical address or a fault with a cause code.

When a translation succeeds, the walker keeps the accessed and dirty flags in memory up to date. It writes an entry back only when one of its flags actually changes, and it does so before the response is given. A faulting walk leaves memory untouched. The block serves one request at a time and holds its request input not-ready while a walk is in flight.

The geometry comes from one parameter: the index width `IDX_W`. Each table has 2^IDX_W entries of 4 bytes, which fill one page exactly. The page offset is IDX_W+2 bits wide and the address is 3*IDX_W+2 bits wide. With the default of 10 these are a 12-bit offset and a 32-bit address.

Top module: `addr_walk_top`

## Requirements
- R1: A successful translation returns the frame field of the table entry (bits 31:12) joined with linear address bits 11:0 as the physical address, with the fault flag low.
- R2: The directory entry is read at {directory frame, linear bits 31:22, 2'b00}. The table entry is read at {directory entry bits 31:12, linear bits 21:12, 2'b00}.
- R3: A directory entry whose present bit (bit 0) is clear gives a not-present fault. The table entry is not read.
- R4: A table entry whose present bit is clear gives a not-present fault, whatever its other bits hold.
- R5: A user access faults with a privilege violation unless the user-allowed bit (bit 2) is set in both entries. This check takes priority over the write check.
- R6: A write at either privilege faults with write-protect unless the writable bit (bit 1) is set in both entries. Reads and fetches ignore the writable bit.
- R7: On success, the accessed bit (bit 5) is set in both entries and the dirty bit (bit 6) is set in the table entry on a write only. Each entry is written back, directory first, only if its value changes.
- R8: A faulting walk performs no memory writes.
- R9: The cause code has 4 bits. Bits [3:2] give the class: 1 not-present, 2 write-protect, 3 privilege. Bits [1:0] give the access kind: 0 read, 1 write, 2 fetch. The cause is zero on success.
- R10: A request is taken when reqValid and reqReady are both high. reqReady stays low until the response, and rspValid is a one-cycle pulse.
- R11: After reset, reqReady is high and rspValid and memValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqAddr | input | 32 | Linear address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| reqUser | input | 1 | 1 for user privilege, 0 for kernel |
| dirBase | input | 20 | Frame number of the page directory |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Translation faulted |
| rspPhys | output | 32 | Physical address (valid when no fault) |
| rspCause | output | 4 | Fault cause code |
| memValid | output | 1 | Memory access request, held until memDone |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry value to write |
| memDone | input | 1 | Memory access complete; read data valid |
| memRdata | input | 32 | Entry value read |

## Verification
The bench uses the default IDX_W of 10, so every address is 32 bits wide and every table has 1024 entries. Its memory model covers the directory at frame 1 and two tables at frames 2 and 3. Mappings placed at several directory and table indices let the bench observe the exact entry addresses on the memory port. The bench also counts reads and writes for each walk. That brings into view the skipped table read after a directory miss, the absence of writes on every kind of fault, and the write-back done only when flags change. Entries with the permission bits set in different ways at each level test privilege against write-protect priority at both levels.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKindT;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RDONLY = 2'd2,
    FLT_PRIV   = 2'd3
  } fltClassT;

  localparam int PRES_BIT  = 0;
  localparam int WR_BIT    = 1;
  localparam int USR_BIT   = 2;
  localparam int ACC_BIT   = 5;
  localparam int DIRTY_BIT = 6;

  typedef struct packed {
    logic capReq;
    logic capDir;
    logic capTbl;
    logic useTbl;
    logic finOk;
    logic finAbsent;
    logic finPerm;
  } strobeT;

endpackage

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    stb,
  input  logic [3*IDX_W+1:0]        reqAddr,
  input  logic [1:0]                reqKind,
  input  logic                      reqUser,
  input  logic [2*IDX_W-1:0]        dirBase,
  input  logic [3*IDX_W+1:0]        memRdata,
  output logic [3*IDX_W+1:0]        memAddr,
  output logic [3*IDX_W+1:0]        memWdata,
  output logic                      rdPresent,
  output logic                      dirNeedWr,
  output logic                      tblNeedWr,
  output logic                      permBad,
  output logic                      rspFault,
  output logic [3*IDX_W+1:0]        rspPhys,
  output logic [3:0]                rspCause
);

  localparam int OFFS_W  = IDX_W + 2;
  localparam int ADDR_W  = 3 * IDX_W + 2;
  localparam int FRAME_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0]  linQ;
  accKindT            kindQ;
  logic               userQ;
  logic [FRAME_W-1:0] baseQ;
  logic [ADDR_W-1:0]  dirQ;
  logic [ADDR_W-1:0]  tblQ;

  logic               isWrite;
  logic               userDeny;
  logic               wrDeny;
  fltClassT           permClass;
  logic [ADDR_W-1:0]  dirNew;
  logic [ADDR_W-1:0]  tblNew;
  logic [ADDR_W-1:0]  setMaskDir;
  logic [ADDR_W-1:0]  setMaskTbl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linQ  <= '0;
      kindQ <= ACC_READ;
      userQ <= 1'b0;
      baseQ <= '0;
    end else if (stb.capReq) begin
      linQ  <= reqAddr;
      kindQ <= accKindT'(reqKind);
      userQ <= reqUser;
      baseQ <= dirBase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      tblQ <= '0;
    end else begin
      if (stb.capDir) dirQ <= memRdata;
      if (stb.capTbl) tblQ <= memRdata;
    end
  end

  assign isWrite = (kindQ == ACC_WRITE);

  always_comb begin
    setMaskDir = '0;
    setMaskDir[ACC_BIT] = 1'b1;
    setMaskTbl = setMaskDir;
    setMaskTbl[DIRTY_BIT] = isWrite;
  end

  assign dirNew    = dirQ | setMaskDir;
  assign tblNew    = tblQ | setMaskTbl;
  assign dirNeedWr = (dirNew != dirQ);
  assign tblNeedWr = (tblNew != tblQ);

  assign userDeny  = userQ && !(dirQ[USR_BIT] && tblQ[USR_BIT]);
  assign wrDeny    = isWrite && !(dirQ[WR_BIT] && tblQ[WR_BIT]);
  assign permBad   = userDeny || wrDeny;
  assign permClass = userDeny ? FLT_PRIV : FLT_RDONLY;

  assign rdPresent = memRdata[PRES_BIT];

  always_comb begin
    if (stb.useTbl) begin
      memAddr  = {dirQ[ADDR_W-1 -: FRAME_W], linQ[OFFS_W +: IDX_W], 2'b00};
      memWdata = tblNew;
    end else begin
      memAddr  = {baseQ, linQ[ADDR_W-1 -: IDX_W], 2'b00};
      memWdata = dirNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspPhys  <= '0;
      rspCause <= '0;
    end else if (stb.finOk) begin
      rspFault <= 1'b0;
      rspPhys  <= {tblQ[ADDR_W-1 -: FRAME_W], linQ[OFFS_W-1:0]};
      rspCause <= '0;
    end else if (stb.finAbsent) begin
      rspFault <= 1'b1;
      rspPhys  <= '0;
      rspCause <= {FLT_ABSENT, kindQ};
    end else if (stb.finPerm) begin
      rspFault <= 1'b1;
      rspPhys  <= '0;
      rspCause <= {permClass, kindQ};
    end
  end

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   memDone,
  input  logic   rdPresent,
  input  logic   dirNeedWr,
  input  logic   tblNeedWr,
  input  logic   permBad,
  output logic   reqReady,
  output logic   rspValid,
  output logic   memValid,
  output logic   memWe,
  output strobeT stb
);

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_TBL_RD, S_CHECK, S_DIR_WR, S_TBL_WR, S_DONE
  } stateT;

  stateT state;
  stateT nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    memValid  = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = S_DIR_RD;
        end
      end
      S_DIR_RD: begin
        memValid = 1'b1;
        if (memDone) begin
          stb.capDir = 1'b1;
          if (rdPresent) begin
            nextState = S_TBL_RD;
          end else begin
            stb.finAbsent = 1'b1;
            nextState     = S_DONE;
          end
        end
      end
      S_TBL_RD: begin
        memValid   = 1'b1;
        stb.useTbl = 1'b1;
        if (memDone) begin
          stb.capTbl = 1'b1;
          if (rdPresent) begin
            nextState = S_CHECK;
          end else begin
            stb.finAbsent = 1'b1;
            nextState     = S_DONE;
          end
        end
      end
      S_CHECK: begin
        if (permBad) begin
          stb.finPerm = 1'b1;
          nextState   = S_DONE;
        end else if (dirNeedWr) begin
          nextState = S_DIR_WR;
        end else if (tblNeedWr) begin
          nextState = S_TBL_WR;
        end else begin
          stb.finOk = 1'b1;
          nextState = S_DONE;
        end
      end
      S_DIR_WR: begin
        memValid = 1'b1;
        memWe    = 1'b1;
        if (memDone) begin
          if (tblNeedWr) begin
            nextState = S_TBL_WR;
          end else begin
            stb.finOk = 1'b1;
            nextState = S_DONE;
          end
        end
      end
      S_TBL_WR: begin
        memValid   = 1'b1;
        memWe      = 1'b1;
        stb.useTbl = 1'b1;
        if (memDone) begin
          stb.finOk = 1'b1;
          nextState = S_DONE;
        end
      end
      S_DONE: begin
        rspValid  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/addr_walk_top.sv
module addr_walk_top
  import walk_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [3*IDX_W+1:0]     reqAddr,
  input  logic [1:0]             reqKind,
  input  logic                   reqUser,
  input  logic [2*IDX_W-1:0]     dirBase,
  output logic                   rspValid,
  output logic                   rspFault,
  output logic [3*IDX_W+1:0]     rspPhys,
  output logic [3:0]             rspCause,
  output logic                   memValid,
  output logic                   memWe,
  output logic [3*IDX_W+1:0]     memAddr,
  output logic [3*IDX_W+1:0]     memWdata,
  input  logic                   memDone,
  input  logic [3*IDX_W+1:0]     memRdata
);

  strobeT stb;
  logic   rdPresent;
  logic   dirNeedWr;
  logic   tblNeedWr;
  logic   permBad;

  walk_ctrl ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .memDone   (memDone),
    .rdPresent (rdPresent),
    .dirNeedWr (dirNeedWr),
    .tblNeedWr (tblNeedWr),
    .permBad   (permBad),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .memValid  (memValid),
    .memWe     (memWe),
    .stb       (stb)
  );

  walk_dp #(.IDX_W(IDX_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqKind   (reqKind),
    .reqUser   (reqUser),
    .dirBase   (dirBase),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rdPresent (rdPresent),
    .dirNeedWr (dirNeedWr),
    .tblNeedWr (tblNeedWr),
    .permBad   (permBad),
    .rspFault  (rspFault),
    .rspPhys   (rspPhys),
    .rspCause  (rspCause)
  );

endmodule

// File: rtl/addr_walk_chk.sv
module addr_walk_chk #(
  parameter int IDX_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqReady,
  input logic               rspValid,
  input logic               rspFault,
  input logic [3:0]         rspCause,
  input logic               memValid,
  input logic               memWe,
  input logic [3*IDX_W+1:0] memAddr,
  input logic [3*IDX_W+1:0] memWdata,
  input logic               memDone
);

  AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memDone) |=> (memValid && $stable(memAddr))); // R2

  AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWe) |-> memWdata[5]); // R7

  AST_FAULT_HAS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspCause[3:2] != 2'd0 && rspCause[1:0] != 2'd3)); // R9

  AST_OK_NO_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspCause == 4'd0)); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R10

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memValid); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R10

endmodule

bind addr_walk_top addr_walk_chk #(.IDX_W(IDX_W)) chkInst (.*);

// File: tb/addr_walk_top_test.sv
`timescale 1ns/1ps
module addr_walk_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [19:0] dirBase = 20'h00001;
  logic        rspValid;
  logic        rspFault;
  logic [31:0] rspPhys;
  logic [3:0]  rspCause;
  logic        memValid;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        memDone;
  logic [31:0] memRdata;

  always #2.5 clk = ~clk;

  addr_walk_top uut (.*);

  // memory model: 16 KB, one-cycle latency, backdoor for setup
  logic [31:0] mem [0:4095];
  logic        bdWe = 1'b0;
  logic [31:0] bdAddr = '0;
  logic [31:0] bdData = '0;
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] rdLog [0:7];
  logic [31:0] wrAddrLog [0:7];
  logic [31:0] wrDataLog [0:7];

  always @(posedge clk) begin
    if (!rstN) begin
      memDone <= 1'b0;
      memRdata <= '0;
      for (int i = 0; i < 4096; i++) mem[i] = '0;
    end else begin
      if (bdWe) mem[bdAddr[13:2]] = bdData;
      if (memValid && !memDone) begin
        memDone <= 1'b1;
        if (memWe) begin
          mem[memAddr[13:2]] = memWdata;
          wrAddrLog[wrCount % 8] <= memAddr;
          wrDataLog[wrCount % 8] <= memWdata;
          wrCount <= wrCount + 1;
        end else begin
          memRdata <= mem[memAddr[13:2]];
          rdLog[rdCount % 8] <= memAddr;
          rdCount <= rdCount + 1;
        end
      end else begin
        memDone <= 1'b0;
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bdWe = 1'b1; bdAddr = a; bdData = d;
    @(negedge clk);
    bdWe = 1'b0;
  endtask

  // results of the last walk
  logic        gFault;
  logic [31:0] gPhys;
  logic [3:0]  gCause;
  logic        gBusy;
  logic        gPulseAfter;
  int          dRd;
  int          dWr;
  int          rd0;
  int          wr0;

  task automatic doWalk(input logic [31:0] la, input logic [1:0] k, input logic u);
    int guard;
    rd0 = rdCount; wr0 = wrCount;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = la; reqKind = k; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    gBusy = reqReady;
    guard = 0;
    while (!rspValid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    gFault = rspFault; gPhys = rspPhys; gCause = rspCause;
    @(negedge clk);
    gPulseAfter = rspValid;
    dRd = rdCount - rd0;
    dWr = wrCount - wr0;
  endtask

  task automatic testReset();
    check("R11 reqReady after reset", {31'd0, reqReady}, 32'd1);
    check("R11 rspValid after reset", {31'd0, rspValid}, 32'd0);
    check("R11 memValid after reset", {31'd0, memValid}, 32'd0);
  endtask

  task automatic testUserRead();
    poke(32'h0000_1014, 32'h0000_2007);
    poke(32'h0000_248C, 32'hABCD_E027);
    doWalk(32'h0152_3ABC, 2'd0, 1'b1);
    check("R10 reqReady low during walk", {31'd0, gBusy}, 32'd0);
    check("R10 rspValid single pulse", {31'd0, gPulseAfter}, 32'd0);
    check("R1 fault flag", {31'd0, gFault}, 32'd0);
    check("R1 phys address", gPhys, 32'hABCD_EABC);
    check("R9 cause on success", {28'd0, gCause}, 32'd0);
    check("R2 read count", dRd, 32'd2);
    check("R2 dir entry addr", rdLog[rd0 % 8], 32'h0000_1014);
    check("R2 table entry addr", rdLog[(rd0 + 1) % 8], 32'h0000_248C);
    check("R7 one write", dWr, 32'd1);
    check("R7 dir writeback addr", wrAddrLog[wr0 % 8], 32'h0000_1014);
    check("R7 dir writeback data", wrDataLog[wr0 % 8], 32'h0000_2027);
  endtask

  task automatic testKernelWrite();
    doWalk(32'h0152_3ABC, 2'd1, 1'b0);
    check("R1 write ok", {31'd0, gFault}, 32'd0);
    check("R7 dirty write count", dWr, 32'd1);
    check("R7 table writeback addr", wrAddrLog[wr0 % 8], 32'h0000_248C);
    check("R7 table dirty data", wrDataLog[wr0 % 8], 32'hABCD_E067);
    doWalk(32'h0152_3ABC, 2'd1, 1'b1);
    check("R7 no writeback when unchanged", dWr, 32'd0);
    check("R1 user write ok phys", gPhys, 32'hABCD_EABC);
  endtask

  task automatic testDirAbsent();
    doWalk(32'h0180_5555, 2'd1, 1'b1);
    check("R3 fault flag", {31'd0, gFault}, 32'd1);
    check("R9 absent write cause", {28'd0, gCause}, 32'h5);
    check("R3 no table read", dRd, 32'd1);
    check("R8 no write on dir fault", dWr, 32'd0);
  endtask

  task automatic testTblAbsent();
    poke(32'h0000_101C, 32'h0000_3027);
    poke(32'h0000_3040, 32'hFFFF_F000);
    doWalk(32'h01C1_0001, 2'd2, 1'b0);
    check("R4 fault flag", {31'd0, gFault}, 32'd1);
    check("R9 absent fetch cause", {28'd0, gCause}, 32'h6);
    check("R2 table addr from dir frame", rdLog[(rd0 + 1) % 8], 32'h0000_3040);
    check("R8 no write on table fault", dWr, 32'd0);
  endtask

  task automatic testPrivilege();
    poke(32'h0000_3044, 32'h1234_5023);
    doWalk(32'h01C1_17F0, 2'd0, 1'b1);
    check("R5 user denied", {28'd0, gCause}, 32'hC);
    check("R8 no write on priv fault", dWr, 32'd0);
    doWalk(32'h01C1_17F0, 2'd0, 1'b0);
    check("R5 kernel allowed", {31'd0, gFault}, 32'd0);
    check("R1 kernel phys", gPhys, 32'h1234_57F0);
  endtask

  task automatic testWriteProtect();
    poke(32'h0000_3048, 32'h2222_2021);
    doWalk(32'h01C1_2004, 2'd1, 1'b1);
    check("R5 priv beats write-protect", {28'd0, gCause}, 32'hD);
    doWalk(32'h01C1_2004, 2'd1, 1'b0);
    check("R6 kernel write to read-only", {28'd0, gCause}, 32'h9);
    check("R8 no write on wp fault", dWr, 32'd0);
    doWalk(32'h01C1_2004, 2'd0, 1'b0);
    check("R6 read ignores writable", gPhys, 32'h2222_2004);
  endtask

  task automatic testDirReadOnly();
    poke(32'h0000_1020, 32'h0000_3005);
    poke(32'h0000_304C, 32'h3333_3067);
    doWalk(32'h0201_3010, 2'd1, 1'b0);
    check("R6 dir level write-protect", {28'd0, gCause}, 32'h9);
    check("R8 no write on dir wp", dWr, 32'd0);
    doWalk(32'h0201_3010, 2'd2, 1'b1);
    check("R6 fetch ok", {31'd0, gFault}, 32'd0);
    check("R1 fetch phys", gPhys, 32'h3333_3010);
    check("R7 fetch writes dir only", dWr, 32'd1);
    check("R7 fetch dir data", wrDataLog[wr0 % 8], 32'h0000_3025);
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUserRead();
    testKernelWrite();
    testDirAbsent();
    testTblAbsent();
    testPrivilege();
    testWriteProtect();
    testDirReadOnly();
    finish();
  end

endmodule